// File: doc/BRIEF.md
# Multiplexed Address Capture Unit

This block sits at the memory side of a synchronous bus where one 16-bit path carries both address and data. It watches the bus clock, an active-low address strobe, an active-low output-enable and the shared lines. From one or two address phases it builds a 32-bit word address. When the low half arrives it fires a single-cycle read-start pulse and opens a burst window of fixed length.

During an address phase the output-enable level selects the half. Low means the phase carries the upper 16 bits. High means it carries the lower 16 bits and starts the read. A read that gives only the lower half reuses the upper half captured most recently.

A burst may be cut short by a new address phase, but only once. After that the next burst must run to its full length. Phases that arrive while this lock is in force are ignored.

A mode bit chooses when a phase is captured. In synchronous mode (bit 0) capture happens on every rising clock edge that sees the strobe low. In asynchronous mode (bit 1) capture happens when the strobe returns high, and the bus and enable values are those sampled in the last clock cycle the strobe was low.

Top module: `mac_capture_top`

## Requirements
- R1: After reset `rd_start`, `burst_active` and `term_flag` are 0, the mode is synchronous, and the held upper half is zero, so a first lower-only read yields address 0x0000_xxxx.
- R2: In synchronous mode, a clock edge that samples `adv_n`=0 and `oe_n`=1 captures the lower half. After that edge `rd_start` is 1 and `rd_addr` = {held upper, `ad_in`}.
- R3: A phase sampled with `oe_n`=0 loads `ad_in` into the held upper half and raises no `rd_start`.
- R4: A lower-only phase combines with the upper half kept from the last upper capture.
- R5: With `adv_n` held low, an upper phase and a lower phase on two consecutive edges produce the full address on the second edge.
- R6: A second upper phase before any lower phase overwrites the held upper half.
- R7: `burst_active` is 1 for exactly BURST_LEN (default 4) cycles after a `rd_start` and then drops to 0, unless an accepted phase intervenes.
- R8: An accepted phase while `burst_active`=1 is an early termination and sets `term_flag`. A lower phase restarts the burst with a new `rd_start`. An upper phase ends the burst at once.
- R9: While `term_flag`=1 and `burst_active`=1, any address phase is ignored: no `rd_start`, and the held upper half is unchanged.
- R10: `term_flag` clears when a burst reaches its full length.
- R11: When `cfg_we`=1, `cfg_async` is loaded as the mode bit. In asynchronous mode no capture occurs while `adv_n` is low. The edge that first sees `adv_n` high captures, using the `oe_n` and `ad_in` sampled on the last low cycle.
- R12: `rd_start` lasts one clock cycle per accepted lower phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the mode bit |
| cfg_async | input | 1 | Mode value: 0 synchronous, 1 asynchronous capture |
| adv_n | input | 1 | Active-low address-valid strobe |
| oe_n | input | 1 | Active-low output-enable, used as half selector during phases |
| ad_in | input | 16 | Shared address/data lines |
| rd_start | output | 1 | One-cycle read-start pulse |
| rd_addr | output | 32 | Captured word address, valid with `rd_start` |
| burst_active | output | 1 | Burst window open |
| term_flag | output | 1 | An early termination has been used |

## Verification
A new lower phase and the final cycle of a running burst can meet on one edge. So can an early termination and the lock that forbids a second one. The vector table drives a lower phase while a burst is open and the flag is clear, then a further phase in the next cycle. The first must restart the burst with a fresh address and set the flag. The second must be dropped. The bench also lets a flagged burst run out and checks that the flag and `burst_active` fall on the same edge.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int HALF_W = 16;

  typedef struct packed {
    logic              vld;
    logic              hi;
    logic [HALF_W-1:0] bits;
  } phase_t;
endpackage

// File: rtl/mac_phase_sense.sv
module mac_phase_sense
  import mac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_async,
  input  logic              adv_n,
  input  logic              oe_n,
  input  logic [HALF_W-1:0] ad_in,
  output phase_t            ph
);
  logic              adv_q, adv_d;
  logic              hold_hi_q, hold_hi_d;
  logic [HALF_W-1:0] hold_bits_q, hold_bits_d;
  logic              hold_en;

  assign hold_en = ~adv_n;

  always_comb begin
    adv_d       = adv_n;
    hold_hi_d   = hold_en ? ~oe_n : hold_hi_q;
    hold_bits_d = hold_en ? ad_in : hold_bits_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adv_q       <= 1'b1;
      hold_hi_q   <= 1'b0;
      hold_bits_q <= '0;
    end else begin
      adv_q       <= adv_d;
      hold_hi_q   <= hold_hi_d;
      hold_bits_q <= hold_bits_d;
    end
  end

  always_comb begin
    if (mode_async) begin
      ph.vld  = ~adv_q & adv_n;
      ph.hi   = hold_hi_q;
      ph.bits = hold_bits_q;
    end else begin
      ph.vld  = ~adv_n;
      ph.hi   = ~oe_n;
      ph.bits = ad_in;
    end
  end
endmodule

// File: rtl/mac_burst_ctrl.sv
module mac_burst_ctrl #(
  parameter int BURST_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ph_vld,
  input  logic ph_hi,
  output logic accept,
  output logic burst_active,
  output logic term_flag
);
  localparam int CNT_W = $clog2(BURST_LEN + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             flag_q, flag_d;
  logic             active, blocked, last;

  assign active  = (cnt_q != '0);
  assign blocked = active & flag_q;
  assign accept  = ph_vld & ~blocked;
  assign last    = (cnt_q == CNT_W'(1));

  always_comb begin
    cnt_d  = cnt_q;
    flag_d = flag_q;
    if (accept && !ph_hi)      cnt_d = CNT_W'(BURST_LEN);
    else if (accept && active) cnt_d = '0;
    else if (active)           cnt_d = cnt_q - CNT_W'(1);

    if (accept && active)      flag_d = 1'b1;
    else if (last)             flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign burst_active = active;
  assign term_flag    = flag_q;
endmodule

// File: rtl/mac_addr_join.sv
module mac_addr_join
  import mac_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                accept,
  input  logic                ph_hi,
  input  logic [HALF_W-1:0]   ph_bits,
  output logic                rd_start,
  output logic [2*HALF_W-1:0] rd_addr
);
  logic [HALF_W-1:0]   upper_q, upper_d;
  logic                start_q, start_d;
  logic [2*HALF_W-1:0] addr_q, addr_d;

  always_comb begin
    upper_d = (accept && ph_hi) ? ph_bits : upper_q;
    start_d = accept & ~ph_hi;
    addr_d  = start_d ? {upper_q, ph_bits} : addr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper_q <= '0;
      start_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      upper_q <= upper_d;
      start_q <= start_d;
      addr_q  <= addr_d;
    end
  end

  assign rd_start = start_q;
  assign rd_addr  = addr_q;
endmodule

// File: rtl/mac_capture_top.sv
module mac_capture_top
  import mac_pkg::*;
#(
  parameter int BURST_LEN = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic                cfg_async,
  input  logic                adv_n,
  input  logic                oe_n,
  input  logic [HALF_W-1:0]   ad_in,
  output logic                rd_start,
  output logic [2*HALF_W-1:0] rd_addr,
  output logic                burst_active,
  output logic                term_flag
);
  logic [1:0] rst_pipe;
  logic       rst_int_n;
  logic       mode_q, mode_d;
  phase_t     ph;
  logic       accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  always_comb mode_d = cfg_we ? cfg_async : mode_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) mode_q <= 1'b0;
    else            mode_q <= mode_d;
  end

  mac_phase_sense u_sense (
    .clk(clk), .rst_n(rst_int_n), .mode_async(mode_q),
    .adv_n(adv_n), .oe_n(oe_n), .ad_in(ad_in), .ph(ph)
  );

  mac_burst_ctrl #(.BURST_LEN(BURST_LEN)) u_burst (
    .clk(clk), .rst_n(rst_int_n), .ph_vld(ph.vld), .ph_hi(ph.hi),
    .accept(accept), .burst_active(burst_active), .term_flag(term_flag)
  );

  mac_addr_join u_join (
    .clk(clk), .rst_n(rst_int_n), .accept(accept), .ph_hi(ph.hi),
    .ph_bits(ph.bits), .rd_start(rd_start), .rd_addr(rd_addr)
  );
endmodule

// File: rtl/mac_capture_chk.sv
module mac_capture_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mode_async,
  input logic        adv_n,
  input logic        oe_n,
  input logic [15:0] ad_in,
  input logic        rd_start,
  input logic [15:0] addr_lo,
  input logic        burst_active,
  input logic        term_flag
);
  // R7: a start always opens the burst window
  a_r7_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start |-> burst_active);

  // R9: a locked burst lets no new read begin
  a_r9_locked_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (term_flag && burst_active) |=> !rd_start);

  // R3: an upper phase in synchronous mode never starts a read
  a_r3_upper_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_async && !adv_n && !oe_n) |=> !rd_start);

  // R8: the termination flag only rises out of an open burst
  a_r8_flag_from_active: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(term_flag) |-> $past(burst_active));

  // R2: synchronous start carries the bus value of the capturing edge
  a_r2_low_half: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_start && !mode_async && !$past(mode_async)) |-> addr_lo == $past(ad_in));
endmodule

bind mac_capture_top mac_capture_chk u_chk (
  .clk(clk), .rst_n(rst_int_n), .mode_async(mode_q), .adv_n(adv_n),
  .oe_n(oe_n), .ad_in(ad_in), .rd_start(rd_start), .addr_lo(rd_addr[15:0]),
  .burst_active(burst_active), .term_flag(term_flag)
);

// File: tb/tb_mac_capture_top.sv
module tb_mac_capture_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 20;

  typedef struct packed {
    logic        adv;
    logic        oe;
    logic [15:0] ad;
    logic        st;
    logic [31:0] addr;
    logic        act;
    logic        trm;
  } vec_t;

  // sync mode, BURST_LEN=4, starting from reset
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 1'b1, 16'h0000, 1'b0, 32'h0, 1'b0, 1'b0},          // idle
    '{1'b0, 1'b1, 16'h1234, 1'b1, 32'h0000_1234, 1'b1, 1'b0}, // R1 R2 lower-only
    '{1'b1, 1'b1, 16'h0000, 1'b0, 32'h0, 1'b1, 1'b0},         // R12
    '{1'b1, 1'b1, 16'h0000, 1'b0, 32'h0, 1'b1, 1'b0},
    '{1'b1, 1'b1, 16'h0000, 1'b0, 32'h0, 1'b1, 1'b0},
    '{1'b1, 1'b1, 16'h0000, 1'b0, 32'h0, 1'b0, 1'b0},         // R7 window ends
    '{1'b0, 1'b0, 16'hABCD, 1'b0, 32'h0, 1'b0, 1'b0},         // R3 upper
    '{1'b0, 1'b1, 16'h0042, 1'b1, 32'hABCD_0042, 1'b1, 1'b0}, // R5
    '{1'b0, 1'b1, 16'h0007, 1'b1, 32'hABCD_0007, 1'b1, 1'b1}, // R8 restart
    '{1'b0, 1'b1, 16'h0009, 1'b0, 32'h0, 1'b1, 1'b1},         // R9 ignored
    '{1'b1, 1'b1, 16'h0000, 1'b0, 32'h0, 1'b1, 1'b1},
    '{1'b1, 1'b1, 16'h0000, 1'b0, 32'h0, 1'b1, 1'b1},
    '{1'b1, 1'b1, 16'h0000, 1'b0, 32'h0, 1'b0, 1'b0},         // R10
    '{1'b0, 1'b1, 16'h0011, 1'b1, 32'hABCD_0011, 1'b1, 1'b0}, // R4
    '{1'b0, 1'b0, 16'h1111, 1'b0, 32'h0, 1'b0, 1'b1},         // R8 upper ends
    '{1'b0, 1'b1, 16'h0022, 1'b1, 32'h1111_0022, 1'b1, 1'b1},
    '{1'b1, 1'b1, 16'h0000, 1'b0, 32'h0, 1'b1, 1'b1},
    '{1'b1, 1'b1, 16'h0000, 1'b0, 32'h0, 1'b1, 1'b1},
    '{1'b1, 1'b1, 16'h0000, 1'b0, 32'h0, 1'b1, 1'b1},
    '{1'b1, 1'b1, 16'h0000, 1'b0, 32'h0, 1'b0, 1'b0}          // R10
  };

  logic        clk;
  logic        rst_n;
  logic        cfg_we, cfg_async, adv_n, oe_n;
  logic [15:0] ad_in;
  logic        rd_start, burst_active, term_flag;
  logic [31:0] rd_addr;
  int          checks;
  int          fails;
  logic        done;

  mac_capture_top dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_async(cfg_async),
    .adv_n(adv_n), .oe_n(oe_n), .ad_in(ad_in), .rd_start(rd_start),
    .rd_addr(rd_addr), .burst_active(burst_active), .term_flag(term_flag)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic a, input logic o, input logic [15:0] d);
    @(negedge clk);
    adv_n = a; oe_n = o; ad_in = d;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; adv_n = 1'b1; oe_n = 1'b1; ad_in = '0;
    cfg_we = 1'b0; cfg_async = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    checks = 0; fails = 0; done = 1'b0;
    do_reset();
    chk("R1 reset start", {31'b0, rd_start}, 32'd0);
    chk("R1 reset active", {31'b0, burst_active}, 32'd0);
    chk("R1 reset flag", {31'b0, term_flag}, 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i].adv, VEC[i].oe, VEC[i].ad);
      chk($sformatf("R2/R7/R8/R9/R10/R12 vec%0d start", i), {31'b0, rd_start}, {31'b0, VEC[i].st});
      chk($sformatf("R7/R8 vec%0d active", i), {31'b0, burst_active}, {31'b0, VEC[i].act});
      chk($sformatf("R8/R10 vec%0d flag", i), {31'b0, term_flag}, {31'b0, VEC[i].trm});
      if (VEC[i].st) chk($sformatf("R4/R5 vec%0d addr", i), rd_addr, VEC[i].addr);
    end

    // R6: repeated upper overwrites
    do_reset();
    step(1'b0, 1'b0, 16'h5555);
    chk("R6 no start on upper", {31'b0, rd_start}, 32'd0);
    step(1'b0, 1'b0, 16'h6666);
    step(1'b0, 1'b1, 16'h0001);
    chk("R6 start", {31'b0, rd_start}, 32'd1);
    chk("R6 addr", rd_addr, 32'h6666_0001);
    step(1'b1, 1'b1, 16'h0000);
    chk("R12 pulse ends", {31'b0, rd_start}, 32'd0);

    // R11: asynchronous capture on strobe rise
    do_reset();
    @(negedge clk); cfg_we = 1'b1; cfg_async = 1'b1;
    @(negedge clk); cfg_we = 1'b0;
    step(1'b0, 1'b1, 16'h00AA);
    chk("R11 no start while low", {31'b0, rd_start}, 32'd0);
    step(1'b0, 1'b1, 16'h00AA);
    chk("R11 still no start", {31'b0, rd_start}, 32'd0);
    step(1'b1, 1'b1, 16'hFFFF);
    chk("R11 start on rise", {31'b0, rd_start}, 32'd1);
    chk("R11 addr", rd_addr, 32'h0000_00AA);
    repeat (5) step(1'b1, 1'b1, 16'h0000);
    chk("R11 burst over", {31'b0, burst_active}, 32'd0);
    step(1'b0, 1'b0, 16'hBEEF);
    step(1'b1, 1'b1, 16'h0000);
    chk("R11 upper no start", {31'b0, rd_start}, 32'd0);
    step(1'b0, 1'b1, 16'h0001);
    step(1'b1, 1'b0, 16'h7777);
    chk("R11 full start", {31'b0, rd_start}, 32'd1);
    chk("R11 full addr", rd_addr, 32'hBEEF_0001);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule